// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block sits on the host side of a parallel NOR flash. It decides whether an embedded program or erase operation inside the flash has finished. After the host pulses `start_i`, the poller issues status reads over a request/acknowledge read channel. It compares the toggle bit (bit 6 of each returned byte) across two consecutive reads. When the bit holds steady, the operation has ended and the flash is back to returning array data. When the bit keeps flipping, the poller looks at the timeout flag (bit 5 of the second read of the pair). If that flag is low, it keeps polling. If the flag is high, it reads two more times before it settles on a verdict.

A completion that lands at the same moment as the timeout flag is still reported as success, because of that extra pair of reads. A genuine failure is reported only after the poller has written the reset command byte 0xF0 over the write channel, which brings the flash back to array-read mode. A parameterised ceiling on polling pairs turns an operation that never finishes into a failure. If the host pulses `start_i` again while reads are in progress, the poller abandons its current pair and begins again from a fresh first pair.

Top module: `flash_toggle_poller`

## Requirements
- R1: While `rst_n` is low, `busy_o`, `done_o`, `fail_o`, `rd_req_o` and `wr_req_o` are 0 and `wr_data_o` is 0x00.
- R2: A `start_i` pulse sampled while `busy_o` is low raises `busy_o` in the next cycle. The first `rd_req_o` rises two cycles after that `start_i` sample.
- R3: `rd_req_o` stays high until `rd_ack_i` is sampled high with it. It is low in the cycle after each accepted acknowledge, and the next read is requested in the cycle after that. An `rd_ack_i` while `rd_req_o` is low is ignored.
- R4: If bit 6 is equal in the two reads of a pair, `done_o` pulses in the cycle after the second acknowledge, whatever bit 5 holds.
- R5: If bit 6 differs within a pair and bit 5 of the second read is 0, a new pair of reads begins.
- R6: If bit 6 differs within a pair and bit 5 of the second read is 1, two more reads are made. If bit 6 is equal across those two, `done_o` pulses.
- R7: If bit 6 also differs across the two re-check reads, `wr_req_o` rises in the cycle after the last acknowledge and holds until `wr_ack_i`. While it is high, `wr_data_o` is 0xF0, and otherwise it is 0x00. `fail_o` pulses in the cycle after the write is acknowledged.
- R8: After MAX_PAIRS consecutive pairs that toggle with bit 5 low, the poller makes no further read and takes the reset-write-then-fail path of R7.
- R9: A `start_i` sampled while busy in a read phase lets the read in flight finish and discards its data. Polling then restarts from a new first pair with the pair count cleared.
- R10: A `start_i` sampled while the reset write is pending is ignored. The write and the `fail_o` pulse proceed unchanged, and no read follows.
- R11: `done_o` and `fail_o` are one-cycle pulses and never high together. `busy_o` falls in the same cycle as one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin (or restart) polling |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | One-cycle pulse: operation completed |
| fail_o | output | 1 | One-cycle pulse: operation failed, reset written |
| rd_req_o | output | 1 | Status read request |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | DW (8) | Status byte returned with the acknowledge |
| wr_req_o | output | 1 | Reset-command write request |
| wr_ack_i | input | 1 | Write acknowledge |
| wr_data_o | output | DW (8) | Write data, 0xF0 while requesting |

## Verification
Each result has a known delay. `busy_o` follows a start by one cycle and the first read request follows it by two. A verdict pulse or the reset write request appears one cycle after the deciding acknowledge, and `fail_o` appears one cycle after the write acknowledge. The bench holds a behavioural reference model that advances on every rising edge from the same inputs the design sees. On every falling edge it compares all six outputs against the model, so each result is checked in exactly the cycle it is due. Per-scenario counts of verdict pulses, consumed status bytes and leftover bytes add end-to-end checks for looping, re-checking, the pair ceiling and restart.

// File: rtl/flash_tbp_pkg.sv
package flash_tbp_pkg;

    // Status byte bit positions decoded by the poller
    localparam int TBP_TOGGLE_BIT  = 6;
    localparam int TBP_TIMEOUT_BIT = 5;

    // Command byte that returns the flash to array-read mode
    localparam logic [7:0] TBP_RESET_CMD = 8'hF0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAIR_A,
        ST_PAIR_B,
        ST_CHK_A,
        ST_CHK_B,
        ST_RSTWR
    } tbp_state_e;

    typedef struct packed {
        tbp_state_e st;
        logic       issued;
        logic       restart;
        logic       busy;
        logic       done;
        logic       fail;
    } tbp_ctl_t;

endpackage

// File: rtl/tbp_rd_port.sv
module tbp_rd_port #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_i,
    input  logic          rd_ack_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          rd_req_o,
    output logic          xfer_o,
    output logic [DW-1:0] xdata_o
);
    logic req_d, req_q;

    always_comb begin
        req_d = issue_i | (req_q & ~rd_ack_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    assign rd_req_o = req_q;
    assign xfer_o   = req_q & rd_ack_i;
    assign xdata_o  = rd_data_i;

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !rd_ack_i) |=> req_q);
    // R3
    rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && rd_ack_i) |=> !req_q);
    // R3
    issue_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |-> !req_q);
endmodule

// File: rtl/tbp_wr_port.sv
module tbp_wr_port
    import flash_tbp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  logic          wr_ack_i,
    output logic          wr_req_o,
    output logic          xfer_o,
    output logic [DW-1:0] wr_data_o
);
    localparam logic [DW-1:0] CMD_WORD = DW'(TBP_RESET_CMD);

    logic req_d, req_q;

    always_comb begin
        req_d = launch_i | (req_q & ~wr_ack_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    assign wr_req_o  = req_q;
    assign xfer_o    = req_q & wr_ack_i;
    assign wr_data_o = req_q ? CMD_WORD : '0;

    // R7
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !wr_ack_i) |=> req_q);
    // R7
    wr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |-> !req_q);
endmodule

// File: rtl/tbp_tog_cmp.sv
module tbp_tog_cmp (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_i,
    input  logic tog_bit_i,
    input  logic tmo_bit_i,
    output logic toggled_o,
    output logic timeout_o
);
    logic first_d, first_q;

    always_comb begin
        first_d = cap_i ? tog_bit_i : first_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) first_q <= 1'b0;
        else        first_q <= first_d;
    end

    assign toggled_o = first_q ^ tog_bit_i;
    assign timeout_o = tmo_bit_i;
endmodule

// File: rtl/tbp_pair_cnt.sv
module tbp_pair_cnt #(
    parameter int MAX_PAIRS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CW = $clog2(MAX_PAIRS + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(MAX_PAIRS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (inc_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == LAST_VAL);

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_VAL);
    // R8
    inc_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> !last_o);
endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
    import flash_tbp_pkg::*;
#(
    parameter int DW        = 8,
    parameter int MAX_PAIRS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          fail_o,
    output logic          rd_req_o,
    input  logic          rd_ack_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          wr_req_o,
    input  logic          wr_ack_i,
    output logic [DW-1:0] wr_data_o
);
    tbp_ctl_t c_d, c_q;

    logic          issue, rd_xfer, wr_xfer, wr_launch;
    logic [DW-1:0] rd_word;
    logic          cap, toggled, timeout;
    logic          cnt_clr, cnt_inc, cnt_last;
    logic          in_read;
    logic          unused_bits;

    tbp_rd_port #(.DW(DW)) u_rd (
        .clk(clk), .rst_n(rst_n), .issue_i(issue), .rd_ack_i(rd_ack_i),
        .rd_data_i(rd_data_i), .rd_req_o(rd_req_o), .xfer_o(rd_xfer),
        .xdata_o(rd_word)
    );

    tbp_wr_port #(.DW(DW)) u_wr (
        .clk(clk), .rst_n(rst_n), .launch_i(wr_launch), .wr_ack_i(wr_ack_i),
        .wr_req_o(wr_req_o), .xfer_o(wr_xfer), .wr_data_o(wr_data_o)
    );

    tbp_tog_cmp u_cmp (
        .clk(clk), .rst_n(rst_n), .cap_i(cap),
        .tog_bit_i(rd_word[TBP_TOGGLE_BIT]), .tmo_bit_i(rd_word[TBP_TIMEOUT_BIT]),
        .toggled_o(toggled), .timeout_o(timeout)
    );

    tbp_pair_cnt #(.MAX_PAIRS(MAX_PAIRS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(cnt_inc),
        .last_o(cnt_last)
    );

    assign unused_bits = ^{rd_word[DW-1:TBP_TOGGLE_BIT+1], rd_word[TBP_TIMEOUT_BIT-1:0]};

    always_comb begin
        in_read = (c_q.st == ST_PAIR_A) || (c_q.st == ST_PAIR_B) ||
                  (c_q.st == ST_CHK_A)  || (c_q.st == ST_CHK_B);
    end

    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        c_d.fail  = 1'b0;
        issue     = 1'b0;
        cap       = 1'b0;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        wr_launch = 1'b0;

        if (start_i && c_q.busy && in_read) c_d.restart = 1'b1;

        case (c_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    c_d.st      = ST_PAIR_A;
                    c_d.issued  = 1'b0;
                    c_d.busy    = 1'b1;
                    c_d.restart = 1'b0;
                    cnt_clr     = 1'b1;
                end
            end
            ST_PAIR_A, ST_PAIR_B, ST_CHK_A, ST_CHK_B: begin
                if (!c_q.issued) begin
                    issue      = 1'b1;
                    c_d.issued = 1'b1;
                end
                if (rd_xfer) begin
                    c_d.issued = 1'b0;
                    if (c_q.restart) begin
                        c_d.st      = ST_PAIR_A;
                        c_d.restart = start_i;
                        cnt_clr     = 1'b1;
                    end else begin
                        case (c_q.st)
                            ST_PAIR_A: begin
                                cap    = 1'b1;
                                c_d.st = ST_PAIR_B;
                            end
                            ST_PAIR_B: begin
                                if (!toggled) begin
                                    c_d.st      = ST_IDLE;
                                    c_d.busy    = 1'b0;
                                    c_d.done    = 1'b1;
                                    c_d.restart = 1'b0;
                                end else if (timeout) begin
                                    c_d.st = ST_CHK_A;
                                end else if (cnt_last) begin
                                    c_d.st      = ST_RSTWR;
                                    c_d.restart = 1'b0;
                                    wr_launch   = 1'b1;
                                end else begin
                                    c_d.st  = ST_PAIR_A;
                                    cnt_inc = 1'b1;
                                end
                            end
                            ST_CHK_A: begin
                                cap    = 1'b1;
                                c_d.st = ST_CHK_B;
                            end
                            default: begin
                                if (!toggled) begin
                                    c_d.st      = ST_IDLE;
                                    c_d.busy    = 1'b0;
                                    c_d.done    = 1'b1;
                                    c_d.restart = 1'b0;
                                end else begin
                                    c_d.st      = ST_RSTWR;
                                    c_d.restart = 1'b0;
                                    wr_launch   = 1'b1;
                                end
                            end
                        endcase
                    end
                end
            end
            ST_RSTWR: begin
                if (wr_xfer) begin
                    c_d.st   = ST_IDLE;
                    c_d.busy = 1'b0;
                    c_d.fail = 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.st      <= ST_IDLE;
            c_q.issued  <= 1'b0;
            c_q.restart <= 1'b0;
            c_q.busy    <= 1'b0;
            c_q.done    <= 1'b0;
            c_q.fail    <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy_o = c_q.busy;
    assign done_o = c_q.done;
    assign fail_o = c_q.fail;

    // R11
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));
    // R11
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o) |=> !(done_o || fail_o));
    // R11
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o || fail_o));
    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    // R7
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && wr_req_o));
    // R10
    wr_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |=> !rd_req_o);
endmodule

// File: tb/flash_toggle_poller_test.sv
module flash_toggle_poller_test;
    localparam int LIMIT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       rd_ack = 1'b0;
    logic       wr_ack = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic       busy, done, fail, rd_req, wr_req;
    logic [7:0] wr_data;

    always #5 clk = ~clk;

    flash_toggle_poller #(.DW(8), .MAX_PAIRS(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy),
        .done_o(done), .fail_o(fail), .rd_req_o(rd_req), .rd_ack_i(rd_ack),
        .rd_data_i(rd_data), .wr_req_o(wr_req), .wr_ack_i(wr_ack),
        .wr_data_o(wr_data)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int n_acc = 0, n_done = 0, n_failp = 0;
    int rd_lat = 1, wr_lat = 1, rd_wait = 0, wr_wait = 0;
    bit stray = 1'b0;
    logic [7:0] rsp_q[$];

    // behavioural reference model
    int  m_phase = 0, m_pairs = 0;
    bit  m_busy = 0, m_done = 0, m_fail = 0, m_rdreq = 0, m_wrreq = 0;
    bit  m_gap = 0, m_pend = 0;
    logic [7:0] got[$];

    task automatic chk(string tag, string nm, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, nm, act, exp, cyc);
        end
    endtask

    task automatic m_ok();
        m_phase = 0; m_busy = 0; m_done = 1; m_pend = 0; got.delete();
    endtask

    task automatic m_bad();
        m_phase = 2; m_wrreq = 1; m_pend = 0; got.delete();
    endtask

    task automatic m_judge();
        if (got.size() == 2) begin
            if (got[0][6] == got[1][6]) m_ok();
            else if (got[1][5]) m_gap = 1;
            else begin
                m_pairs++;
                if (m_pairs == LIMIT) m_bad();
                else begin got.delete(); m_gap = 1; end
            end
        end else if (got.size() == 4) begin
            if (got[2][6] == got[3][6]) m_ok();
            else m_bad();
        end else begin
            m_gap = 1;
        end
    endtask

    always @(posedge clk) begin
        bit was_read;
        was_read = (m_phase == 1);
        m_done = 0;
        m_fail = 0;
        if (!rst_n) begin
            m_phase = 0; m_busy = 0; m_rdreq = 0; m_wrreq = 0;
            m_gap = 0; m_pend = 0; m_pairs = 0; got.delete();
        end else begin
            case (m_phase)
                0: if (start) begin
                    m_phase = 1; m_busy = 1; m_gap = 1; m_rdreq = 0;
                    m_pairs = 0; m_pend = 0; got.delete();
                end
                1: begin
                    if (m_rdreq && rd_ack) begin
                        m_rdreq = 0;
                        if (m_pend) begin
                            got.delete(); m_pairs = 0; m_gap = 1; m_pend = 0;
                        end else begin
                            got.push_back(rd_data);
                            m_judge();
                        end
                    end else if (m_gap) begin
                        m_rdreq = 1; m_gap = 0;
                    end
                    if (start && was_read && m_phase == 1) m_pend = 1;
                end
                default: if (m_wrreq && wr_ack) begin
                    m_wrreq = 0; m_fail = 1; m_busy = 0; m_phase = 0;
                end
            endcase
        end
    end

    // per-cycle comparison, pulse counting, flash responder, watchdog
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk("R2/R11", "busy",    busy,    m_busy);
            chk("R3",     "rd_req",  rd_req,  m_rdreq);
            chk("R4/R11", "done",    done,    m_done);
            chk("R7/R11", "fail",    fail,    m_fail);
            chk("R7",     "wr_req",  wr_req,  m_wrreq);
            chk("R7",     "wr_data", wr_data, m_wrreq ? 8'hF0 : 8'h00);
            if (done) n_done++;
            if (fail) n_failp++;
        end
        rd_ack = 1'b0;
        if (rd_req) begin
            rd_wait++;
            if (rd_wait >= rd_lat) begin
                rd_ack = 1'b1;
                rd_data = (rsp_q.size() > 0) ? rsp_q.pop_front() : 8'h00;
                rd_wait = 0;
                n_acc++;
            end
        end else if (stray) begin
            rd_ack = 1'b1; rd_data = 8'h40; stray = 1'b0;
        end
        wr_ack = 1'b0;
        if (wr_req) begin
            wr_wait++;
            if (wr_wait >= wr_lat) begin wr_ack = 1'b1; wr_wait = 0; end
        end
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_end();
        int g = 0;
        do begin @(negedge clk); g++; end while (m_phase != 0 && g < 2000);
        repeat (3) @(negedge clk);
    endtask

    task automatic outcome(string tag, int d0, int f0, int a0, int ed, int ef, int ea, int left);
        chk(tag, "done pulses", n_done - d0, ed);
        chk(tag, "fail pulses", n_failp - f0, ef);
        chk(tag, "reads",       n_acc - a0, ea);
        chk(tag, "bytes left",  rsp_q.size(), left);
    endtask

    task automatic run(string tag, int lat, int ed, int ef, int ea, int left);
        int d0, f0, a0;
        d0 = n_done; f0 = n_failp; a0 = n_acc;
        rd_lat = lat;
        pulse_start();
        wait_end();
        outcome(tag, d0, f0, a0, ed, ef, ea, left);
    endtask

    initial begin
        int d0, f0, a0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy",    busy,    0);
        chk("R1", "done",    done,    0);
        chk("R1", "fail",    fail,    0);
        chk("R1", "rd_req",  rd_req,  0);
        chk("R1", "wr_req",  wr_req,  0);
        chk("R1", "wr_data", wr_data, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4: steady toggle bit, with and without bit 5
        rsp_q = '{8'h40, 8'h40};
        run("R4", 1, 1, 0, 2, 0);
        rsp_q = '{8'h60, 8'h60};
        run("R4", 2, 1, 0, 2, 0);

        // R5: toggling pairs with bit 5 low on the second read
        rsp_q = '{8'h00, 8'h40, 8'h60, 8'h00, 8'h00, 8'h00};
        run("R5", 2, 1, 0, 6, 0);

        // R6: timeout flag seen, re-check shows steady bit
        rsp_q = '{8'h00, 8'h60, 8'h20, 8'h20};
        run("R6", 3, 1, 0, 4, 0);

        // R7: re-check still toggles -> reset write, then fail
        wr_lat = 2;
        rsp_q = '{8'h40, 8'h20, 8'h40, 8'h00};
        run("R7", 1, 0, 1, 4, 0);

        // R8: pair ceiling reached, spare bytes untouched
        rsp_q = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h00};
        run("R8", 1, 0, 1, 8, 2);
        rsp_q.delete();

        // R9: restart mid-poll discards the read in flight and clears the count
        rsp_q = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'hFF,
                  8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h20, 8'h20};
        d0 = n_done; f0 = n_failp; a0 = n_acc;
        rd_lat = 4;
        pulse_start();
        do @(posedge clk); while (n_acc - a0 < 6);
        @(negedge clk);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_end();
        outcome("R9", d0, f0, a0, 1, 0, 15, 0);

        // R10: start during the reset write is ignored
        wr_lat = 6;
        rsp_q = '{8'h40, 8'h20, 8'h40, 8'h00, 8'h00, 8'h00};
        d0 = n_done; f0 = n_failp; a0 = n_acc;
        rd_lat = 1;
        pulse_start();
        do @(posedge clk); while (!wr_req);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_end();
        outcome("R10", d0, f0, a0, 0, 1, 4, 2);
        rsp_q.delete();

        // R3: acknowledge while no request is ignored
        d0 = n_done; f0 = n_failp; a0 = n_acc;
        stray = 1'b1;
        repeat (5) @(negedge clk);
        chk("R3", "busy after stray ack", busy, 0);
        outcome("R3", d0, f0, a0, 0, 0, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule